// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Prioritised Peripheral Takeover

This block is one general-purpose I/O port on a simple register bus. Software sets a stored output value and a direction per pin, reads the pins back, and can watch the raw pad states through a read-only view. The block drives the pad output values and output enables. Every pad input passes through a two-flop synchroniser before any register read or peripheral input uses it.

Two pins are shared with peripheral cores that sit outside this block. Pin 1 carries a serial-peripheral master-out line or a UART transmit line. Pin 0 carries the serial-peripheral master-in line or the UART receive line. Ownership of the two shared pins follows a fixed priority. The SPI comes first, the UART second and plain GPIO last. The remaining pins are always GPIO.

Software writes to the stored data bits are always accepted, even while a peripheral owns a pin. The stored value reaches the pad once GPIO owns the pin again.

Top module: `gpio_altfn_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every direction bit and every stored data bit is 0. With no peripheral enabled, every pad output enable is therefore 0.
- R2: A GPIO-owned pin whose direction bit is 1 has its output enable at 1 and drives its stored data bit. A pin whose direction bit is 0 has its output enable at 0.
- R3: A read at offset 0 returns, for each bit, the stored data bit when that pin's direction bit is 1. When the direction bit is 0, it returns the synchronised pad state.
- R4: A read at offset 1 returns the synchronised pad states of all eight pins, whatever the direction and ownership settings. This includes output pins whose pad level differs from the driven value.
- R5: A write at offset 1 changes neither the stored data nor the direction bits.
- R6: While spi_en is 1, pin 1 takes its value and enable from spi_mosi_out and spi_mosi_oe, and pin 0 takes them from spi_miso_out and spi_miso_oe. This holds whatever uart_en, the direction bits and the data bits are.
- R7: While spi_en is 0 and uart_en is 1, pin 1 is always driven with uart_txd, with its enable at 1. Pin 0 has its enable at 0 and its output value at 0.
- R8: A change on pad_in is not visible at the register reads after one rising clock edge. It is visible after two.
- R9: Writes at offset 0 are stored while a peripheral owns a pin. When ownership returns to GPIO, the pin drives the newly stored bit.
- R10: Offset 2 reads and writes the direction bits. Offset 3 reads as 0, and writes to it change nothing. bus_rdata is 0 when bus_sel is 0 or bus_wr is 1.
- R11: uart_rxd and spi_miso_in follow the synchronised state of pad 0, and spi_mosi_in follows the synchronised state of pad 1, under any ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 data, 1 pin input, 2 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| spi_en | input | 1 | SPI takes the shared pins |
| spi_mosi_out | input | 1 | SPI value for pin 1 |
| spi_mosi_oe | input | 1 | SPI enable for pin 1 |
| spi_miso_out | input | 1 | SPI value for pin 0 |
| spi_miso_oe | input | 1 | SPI enable for pin 0 |
| spi_mosi_in | output | 1 | Synchronised pad 1 to the SPI |
| spi_miso_in | output | 1 | Synchronised pad 0 to the SPI |
| uart_en | input | 1 | UART takes the shared pins |
| uart_txd | input | 1 | UART transmit value for pin 1 |
| uart_rxd | output | 1 | Synchronised pad 0 to the UART |

## Verification
The hardest case to reach is a data-register write that lands while a peripheral owns the pin. The new value stays invisible at the pad until ownership drops back to GPIO, and a fault there hides behind the peripheral's drive. The random stimulus toggles spi_en and uart_en between writes, with both enables sometimes set together. A directed sequence writes under SPI ownership, then under UART ownership, releases each in turn, and checks that the pad shows the newest stored bit. A second directed case drives an output pin's pad against its driven value. This shows offset 0 and offset 1 giving different answers.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADR_W  = 2;

  localparam logic [ADR_W-1:0] OFS_DATA = 2'd0;
  localparam logic [ADR_W-1:0] OFS_PINS = 2'd1;
  localparam logic [ADR_W-1:0] OFS_DIR  = 2'd2;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_UART = 2'd1,
    OWN_SPI  = 2'd2
  } pin_owner_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  // Not reset: the pin view is left alone by reset.
  always_comb begin
    stage_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) stage_q[g] <= stage_d[g];
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = ADR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  bus_rdata
);
  logic         wr_data_en, wr_dir_en, rd_en;
  logic [W-1:0] data_d, dir_d;

  assign wr_data_en = bus_sel && bus_wr && (bus_addr == OFS_DATA);
  assign wr_dir_en  = bus_sel && bus_wr && (bus_addr == OFS_DIR);
  assign rd_en      = bus_sel && !bus_wr;

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    if (wr_data_en) data_d = bus_wdata;
    if (wr_dir_en)  dir_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        OFS_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_sync);
        OFS_PINS: bus_rdata = pin_sync;
        OFS_DIR:  bus_rdata = dir_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R1: reset clears direction and data
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '0 && data_q == '0));

  // R5: writes to the pin view leave the registers untouched
  p_pins_readonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_PINS) |=> ($stable(data_q) && $stable(dir_q)));

  // R4: the pin view reads the synchroniser output
  p_pin_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_PINS) |-> (bus_rdata == pin_sync));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned W        = PORT_W,
  parameter int unsigned MOSI_PIN = 1,
  parameter int unsigned MISO_PIN = 0
) (
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pin_sync,
  input  logic         spi_en,
  input  logic         spi_mosi_out,
  input  logic         spi_mosi_oe,
  input  logic         spi_miso_out,
  input  logic         spi_miso_oe,
  input  logic         uart_en,
  input  logic         uart_txd,
  output logic         spi_mosi_in,
  output logic         spi_miso_in,
  output logic         uart_rxd,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  pin_owner_e shared_owner;

  always_comb begin
    if (spi_en)       shared_owner = OWN_SPI;
    else if (uart_en) shared_owner = OWN_UART;
    else              shared_owner = OWN_GPIO;
  end

  generate
    for (genvar p = 0; p < W; p++) begin : g_pin
      if (p == MOSI_PIN) begin : g_mosi
        always_comb begin
          unique case (shared_owner)
            OWN_SPI:  begin pad_out[p] = spi_mosi_out; pad_oe[p] = spi_mosi_oe; end
            OWN_UART: begin pad_out[p] = uart_txd;     pad_oe[p] = 1'b1;        end
            default:  begin pad_out[p] = data_q[p];    pad_oe[p] = dir_q[p];    end
          endcase
        end
      end else if (p == MISO_PIN) begin : g_miso
        always_comb begin
          unique case (shared_owner)
            OWN_SPI:  begin pad_out[p] = spi_miso_out; pad_oe[p] = spi_miso_oe; end
            OWN_UART: begin pad_out[p] = 1'b0;         pad_oe[p] = 1'b0;        end
            default:  begin pad_out[p] = data_q[p];    pad_oe[p] = dir_q[p];    end
          endcase
        end
      end else begin : g_plain
        assign pad_out[p] = data_q[p];
        assign pad_oe[p]  = dir_q[p];
      end
    end
  endgenerate

  assign spi_mosi_in = pin_sync[MOSI_PIN];
  assign spi_miso_in = pin_sync[MISO_PIN];
  assign uart_rxd    = pin_sync[MISO_PIN];

  // R6: SPI wins over everything on the shared pins
  always_comb begin
    if (spi_en === 1'b1) begin
      p_spi_owns_r6: assert (pad_oe[MOSI_PIN] == spi_mosi_oe && pad_oe[MISO_PIN] == spi_miso_oe &&
                             pad_out[MOSI_PIN] == spi_mosi_out && pad_out[MISO_PIN] == spi_miso_out);
    end
  end

  // R7: UART transmit always driven, receive never driven
  always_comb begin
    if (spi_en === 1'b0 && uart_en === 1'b1) begin
      p_uart_owns_r7: assert (pad_oe[MOSI_PIN] && !pad_oe[MISO_PIN] && pad_out[MOSI_PIN] == uart_txd);
    end
  end
endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = PORT_W,
  parameter int unsigned AW          = ADR_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MOSI_PIN    = 1,
  parameter int unsigned MISO_PIN    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic          spi_en,
  input  logic          spi_mosi_out,
  input  logic          spi_mosi_oe,
  input  logic          spi_miso_out,
  input  logic          spi_miso_oe,
  output logic          spi_mosi_in,
  output logic          spi_miso_in,
  input  logic          uart_en,
  input  logic          uart_txd,
  output logic          uart_rxd
);
  logic [1:0]   rst_pipe_q;
  logic         rst_int_n;
  logic [W-1:0] pin_sync, data_q, dir_q;

  // Asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  gpio_pad_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (pad_in),
    .q_sync  (pin_sync)
  );

  gpio_port_regs #(.W(W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_sync  (pin_sync),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .bus_rdata (bus_rdata)
  );

  gpio_pin_mux #(.W(W), .MOSI_PIN(MOSI_PIN), .MISO_PIN(MISO_PIN)) u_mux (
    .data_q       (data_q),
    .dir_q        (dir_q),
    .pin_sync     (pin_sync),
    .spi_en       (spi_en),
    .spi_mosi_out (spi_mosi_out),
    .spi_mosi_oe  (spi_mosi_oe),
    .spi_miso_out (spi_miso_out),
    .spi_miso_oe  (spi_miso_oe),
    .uart_en      (uart_en),
    .uart_txd     (uart_txd),
    .spi_mosi_in  (spi_mosi_in),
    .spi_miso_in  (spi_miso_in),
    .uart_rxd     (uart_rxd),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe)
  );

  // R2: plain GPIO pins follow their direction bit
  p_gpio_oe_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pad_oe[W-1] == dir_q[W-1]) && (!dir_q[W-1] || pad_out[W-1] == data_q[W-1]));
endmodule

// File: tb/gpio_altfn_port_tb.sv
module gpio_altfn_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic       spi_en, spi_mosi_out, spi_mosi_oe, spi_miso_out, spi_miso_oe;
  logic       spi_mosi_in, spi_miso_in, uart_en, uart_txd, uart_rxd;

  int total = 0, bad = 0;
  logic [7:0] m_data, m_dir, m_pad;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_altfn_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .spi_en(spi_en), .spi_mosi_out(spi_mosi_out), .spi_mosi_oe(spi_mosi_oe),
    .spi_miso_out(spi_miso_out), .spi_miso_oe(spi_miso_oe), .spi_mosi_in(spi_mosi_in),
    .spi_miso_in(spi_miso_in), .uart_en(uart_en), .uart_txd(uart_txd), .uart_rxd(uart_rxd)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_pads(input logic [7:0] d, input logic [7:0] r,
      input logic se, input logic ue, input logic mo, input logic moe, input logic mi,
      input logic mie, input logic tx);
    logic [7:0] o = d, e = r;
    if (se) begin o[1] = mo; e[1] = moe; o[0] = mi; e[0] = mie; end
    else if (ue) begin o[1] = tx; e[1] = 1'b1; o[0] = 1'b0; e[0] = 1'b0; end
    return {o, e};
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == 2'd0) m_data = d;
    if (a == 2'd2) m_dir = d;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_pads(input logic [7:0] p);
    @(negedge clk); pad_in = p; m_pad = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] rd;
    bus_read(2'd0, rd); check({"R3 ", tag}, {8'h0, rd}, {8'h0, (m_dir & m_data) | (~m_dir & m_pad)});
    bus_read(2'd1, rd); check({"R4 ", tag}, {8'h0, rd}, {8'h0, m_pad});
    bus_read(2'd2, rd); check({"R10 ", tag}, {8'h0, rd}, {8'h0, m_dir});
    check({"R2/R6/R7 ", tag}, {pad_out, pad_oe}, exp_pads(m_data, m_dir, spi_en, uart_en,
          spi_mosi_out, spi_mosi_oe, spi_miso_out, spi_miso_oe, uart_txd));
    check({"R11 ", tag}, {13'h0, uart_rxd, spi_miso_in, spi_mosi_in}, {13'h0, m_pad[0], m_pad[0], m_pad[1]});
  endtask

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pad_in = 8'h00;
    spi_en = 0; spi_mosi_out = 0; spi_mosi_oe = 0; spi_miso_out = 0; spi_miso_oe = 0;
    uart_en = 0; uart_txd = 0;
    m_data = 0; m_dir = 0; m_pad = 0;
    repeat (4) @(negedge clk);
    // R1: while reset is held
    check("R1 oe in reset", {8'h0, pad_oe}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(2'd2, rd); check("R1 dir after reset", {8'h0, rd}, 16'h0);
    check("R1 pads after reset", {pad_out, pad_oe}, 16'h0);

    // R8: two-edge synchroniser latency
    pad_in = 8'hA5;
    @(negedge clk); bus_read(2'd1, rd); check("R8 one edge", {8'h0, rd}, 16'h0000);
    @(negedge clk); bus_read(2'd1, rd); check("R8 two edges", {8'h0, rd}, 16'h00A5);
    m_pad = 8'hA5;

    // R3/R4: output pin pulled away from its driven value
    bus_write(2'd0, 8'hF0); bus_write(2'd2, 8'hFF);
    set_pads(8'h0F);
    bus_read(2'd0, rd); check("R3 out pin reads latch", {8'h0, rd}, 16'h00F0);
    bus_read(2'd1, rd); check("R4 out pin reads pad", {8'h0, rd}, 16'h000F);

    // R5: write to pin view
    bus_write(2'd1, 8'h3C);
    check_all("after pin-view write R5");
    // R10: offset 3 write ignored, reads 0, rdata 0 when idle
    bus_write(2'd3, 8'h55);
    check_all("after offset3 write R10");
    bus_read(2'd3, rd); check("R10 offset3 reads 0", {8'h0, rd}, 16'h0);
    bus_addr = 2'd2; #1 check("R10 idle rdata 0", {8'h0, bus_rdata}, 16'h0);

    // R9: write while SPI then UART own the pins
    @(negedge clk); spi_en = 1; uart_en = 1; spi_mosi_out = 0; spi_mosi_oe = 0;
    spi_miso_out = 1; spi_miso_oe = 1;
    bus_write(2'd0, 8'h03);
    @(negedge clk); #1 check_all("R6 spi over uart");
    spi_en = 0; uart_txd = 0;
    bus_write(2'd0, 8'h00);
    @(negedge clk); #1 check_all("R7 uart");
    bus_write(2'd0, 8'h02);
    uart_en = 0;
    @(negedge clk); #1 check("R9 released pins", {pad_out, pad_oe}, {8'h02, 8'hFF});

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned op = $urandom_range(0, 5);
      case (op)
        0: bus_write(2'd0, 8'($urandom));
        1: bus_write(2'd2, 8'($urandom));
        2: bus_write(2'($urandom), 8'($urandom));
        3: set_pads(8'($urandom));
        default: begin
          @(negedge clk);
          spi_en = 1'($urandom); uart_en = 1'($urandom); uart_txd = 1'($urandom);
          spi_mosi_out = 1'($urandom); spi_mosi_oe = 1'($urandom);
          spi_miso_out = 1'($urandom); spi_miso_oe = 1'($urandom);
        end
      endcase
      @(negedge clk); #1 check_all("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule